// File: doc/BRIEF.md
# Translation Table Walker

This block turns one input (device-virtual) address into an output physical address by walking a multi-level, 64-bit-descriptor translation table kept in memory. A request supplies the input address and whether the access reads or writes. The walker fetches one 64-bit descriptor at a time through a request/response memory port. It classifies each descriptor and either descends to the next table or stops at a leaf. It ends each request with a one-cycle `done` pulse carrying a fault code and the translated address.

The walk is set by configuration inputs, which are sampled when a request is accepted:
- the root table base;
- a run-time granule size (4 KB, 16 KB or 64 KB), which fixes the per-level index shift and the block sizes that are legal;
- the level the walk starts at;
- an input-size field that bounds the legal input range;
- two flags, bypass and disable, that skip translation.

Write permission is narrowed at every level the walk passes through. Three kinds of fault are reported separately.

Top module: `xlat_walker`

## Requirements
- R1: After reset `done` and `mem_rd_valid` are low, `fault` is 0 and `out_pa` is 0.
- R2: The granule code is 0 for 4 KB (g=12), 1 for 16 KB (g=14) and 2 for 64 KB (g=16). Code 3 gives fault 1 with no memory read. At level L the shift is g+(3-L)(g-3), and the index is (va >> shift) masked to g-3 bits. Each descriptor is read at table base + 8*index. The walk starts at `cfg_start_lvl`, with the base taken from `cfg_tbl_base[47:0]`.
- R3: Descriptor bit 0 clear is invalid. At level 3, type bits [1:0]=01 are reserved. Either case ends the walk with fault code 1 (translation).
- R4: At levels 0 to 2, type 11 is a table and type 01 is a block. A block is legal only for 4 KB at level 1 or 2, 16 KB at level 2, or 64 KB at level 2; its size is 2^shift of its level. Any other block ends the walk with fault code 2. At level 3, type 11 is a page.
- R5: Next-table and leaf addresses come from descriptor bits [46:n] with the low n bits forced to zero. For tables and pages n is g; for blocks n is the block exponent. Descriptor bits above 46 and below n do not change the result.
- R6: On success `out_pa` is the leaf address plus the input address bits below the leaf exponent.
- R7: Read is always granted. Write is granted only when every table on the path has bit 62 clear and the leaf has bit 7 clear. A write that is not granted gives fault code 3.
- R8: A memory response flagged with an error ends the walk with fault code 2.
- R9: With `cfg_bypass` or `cfg_disable` set, a request completes with fault 0, `out_pa` equal to the input address, and no memory read.
- R10: An input address at or above 2^(64-`cfg_tsz`)-1 gives fault code 1 with no memory read.
- R11: At most one memory read is outstanding at a time. `done` is high for exactly one cycle per request. Whenever the fault code is non-zero, `out_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_va | input | 48 | Input address |
| req_rd | input | 1 | Read access requested (always grantable) |
| req_wr | input | 1 | Write access requested |
| cfg_tbl_base | input | 64 | Root table base; bits [47:0] used |
| cfg_gran | input | 2 | Granule code |
| cfg_start_lvl | input | 2 | Starting level |
| cfg_tsz | input | 6 | Input-size field |
| cfg_bypass | input | 1 | Skip translation |
| cfg_disable | input | 1 | Skip translation |
| mem_rd_valid | output | 1 | One-cycle descriptor read request |
| mem_rd_addr | output | 48 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | Request finished (one cycle) |
| fault | output | 2 | 0 none, 1 translation, 2 external abort, 3 permission |
| out_pa | output | 48 | Translated address |

## Verification
The bench drives four-level page walks and level-1 and level-2 blocks under the 4 KB granule, and page and block walks under the 16 KB and 64 KB granules. Comparing these shows whether the shift, the index width and the leaf mask follow the granule and the level.

Leaves that are read-only, and tables that are read-only above writable leaves, are each tried with read and with write. This separates the leaf access bit from narrowing along the path.

The fault cases are an invalid entry, a reserved level-3 entry, an illegal level-0 block and a flagged memory error; these tell the translation fault apart from the abort fault. Bypass, disable, the reserved granule code and the input-limit edge (limit minus one against the limit itself) are told apart by the number of descriptor reads each causes.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int VA_W    = 48;
    localparam int DESC_W  = 64;
    localparam int OA_MSB  = 46;
    localparam int LEAF_AP = 7;
    localparam int TBL_AP  = 62;
    localparam int TSZ_W   = 6;
    localparam int LIM_W   = 65;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_XLAT   = 2'd1,
        FLT_EXTABT = 2'd2,
        FLT_PERM   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DECODE,
        ST_DONE,
        ST_FAULT
    } state_e;

    typedef enum logic [1:0] {
        DK_TABLE,
        DK_LEAF,
        DK_XLAT,
        DK_ABORT
    } dkind_e;

    typedef struct packed {
        dkind_e          kind;
        logic [VA_W-1:0] base;
        logic [5:0]      lexp;
        logic            wr_ok;
    } dinfo_t;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            want_wr;
        logic [1:0]      gran;
    } ctx_t;

    function automatic logic [4:0] gran_exp(input logic [1:0] g);
        case (g)
            2'd1:    return 5'd14;
            2'd2:    return 5'd16;
            default: return 5'd12;
        endcase
    endfunction

    function automatic logic [5:0] lvl_shift(input logic [4:0] ge, input logic [1:0] lvl);
        int s;
        s = int'(ge) + (3 - int'(lvl)) * (int'(ge) - 3);
        return s[5:0];
    endfunction

    function automatic logic block_legal(input logic [1:0] g, input logic [1:0] lvl);
        case (g)
            2'd0:    return (lvl == 2'd1) || (lvl == 2'd2);
            2'd1:    return lvl == 2'd2;
            2'd2:    return lvl == 2'd2;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] low_mask(input logic [5:0] e);
        return (VA_W'(1) << e) - VA_W'(1);
    endfunction

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] tbl_base,
    input  logic [1:0]      gran,
    input  logic [1:0]      lvl,
    output logic [VA_W-1:0] desc_addr
);
    logic [4:0]      ge;
    logic [5:0]      sh;
    logic [VA_W-1:0] idx_mask;
    logic [VA_W-1:0] idx;

    always_comb begin
        ge        = gran_exp(gran);
        sh        = lvl_shift(ge, lvl);
        idx_mask  = (VA_W'(1) << (ge - 5'd3)) - VA_W'(1);
        idx       = (va >> sh) & idx_mask;
        desc_addr = tbl_base + (idx << 3);
    end
endmodule

// File: rtl/xw_desc_decode.sv
module xw_desc_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic              rsp_err,
    input  logic [1:0]        gran,
    input  logic [1:0]        lvl,
    output dinfo_t            info
);
    logic [4:0]      ge;
    logic [5:0]      sh;
    logic [VA_W-1:0] oa;
    logic [1:0]      dtype;
    logic            unused_desc;

    assign unused_desc = ^{desc[DESC_W-1], desc[TBL_AP-1:OA_MSB+1]};

    always_comb begin
        ge         = gran_exp(gran);
        sh         = lvl_shift(ge, lvl);
        oa         = VA_W'(desc[OA_MSB:0]);
        dtype      = desc[1:0];
        info.kind  = DK_XLAT;
        info.lexp  = sh;
        info.wr_ok = ~desc[LEAF_AP];
        info.base  = oa & ~low_mask(sh);
        if (rsp_err) begin
            info.kind = DK_ABORT;
        end else if (!dtype[0]) begin
            info.kind = DK_XLAT;
        end else if (lvl == 2'd3) begin
            info.kind = dtype[1] ? DK_LEAF : DK_XLAT;
        end else if (dtype[1]) begin
            info.kind  = DK_TABLE;
            info.lexp  = 6'(ge);
            info.base  = oa & ~low_mask(6'(ge));
            info.wr_ok = ~desc[TBL_AP];
        end else begin
            info.kind = block_legal(gran, lvl) ? DK_LEAF : DK_ABORT;
        end
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [63:0]       cfg_tbl_base,
    input  logic [1:0]        cfg_gran,
    input  logic [1:0]        cfg_start_lvl,
    input  logic [TSZ_W-1:0]  cfg_tsz,
    input  logic              cfg_bypass,
    input  logic              cfg_disable,
    output logic              mem_rd_valid,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done,
    output logic [1:0]        fault,
    output logic [VA_W-1:0]   out_pa
);
    state_e            state_q;
    ctx_t              ctx_q;
    logic [1:0]        lvl_q;
    logic [VA_W-1:0]   base_q;
    logic              wr_path_q;
    logic [DESC_W-1:0] desc_q;
    logic              err_q;
    fault_e            fault_q;
    logic [VA_W-1:0]   pa_q;
    dinfo_t            info;
    logic [LIM_W-1:0]  va_limit;
    logic              out_of_range;
    logic              unused_top;

    assign unused_top = ^{req_rd, cfg_tbl_base[63:VA_W]};

    always_comb begin
        va_limit     = (LIM_W'(1) << (7'd64 - 7'(cfg_tsz))) - LIM_W'(1);
        out_of_range = LIM_W'(req_va) >= va_limit;
    end

    xw_addr_gen u_addr (
        .va        (ctx_q.va),
        .tbl_base  (base_q),
        .gran      (ctx_q.gran),
        .lvl       (lvl_q),
        .desc_addr (mem_rd_addr)
    );

    xw_desc_decode u_dec (
        .desc    (desc_q),
        .rsp_err (err_q),
        .gran    (ctx_q.gran),
        .lvl     (lvl_q),
        .info    (info)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            lvl_q     <= '0;
            base_q    <= '0;
            wr_path_q <= 1'b0;
            desc_q    <= '0;
            err_q     <= 1'b0;
            fault_q   <= FLT_NONE;
            pa_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx_q.va      <= req_va;
                        ctx_q.want_wr <= req_wr;
                        ctx_q.gran    <= cfg_gran;
                        lvl_q         <= cfg_start_lvl;
                        base_q        <= cfg_tbl_base[VA_W-1:0];
                        wr_path_q     <= 1'b1;
                        if (cfg_bypass || cfg_disable) begin
                            pa_q    <= req_va;
                            fault_q <= FLT_NONE;
                            state_q <= ST_DONE;
                        end else if (cfg_gran == 2'd3 || out_of_range) begin
                            pa_q    <= '0;
                            fault_q <= FLT_XLAT;
                            state_q <= ST_FAULT;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        desc_q  <= mem_rsp_data;
                        err_q   <= mem_rsp_err;
                        state_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    case (info.kind)
                        DK_TABLE: begin
                            base_q    <= info.base;
                            lvl_q     <= lvl_q + 2'd1;
                            wr_path_q <= wr_path_q & info.wr_ok;
                            state_q   <= ST_FETCH;
                        end
                        DK_LEAF: begin
                            if (ctx_q.want_wr && !(wr_path_q && info.wr_ok)) begin
                                pa_q    <= '0;
                                fault_q <= FLT_PERM;
                                state_q <= ST_FAULT;
                            end else begin
                                pa_q    <= info.base | (ctx_q.va & low_mask(info.lexp));
                                fault_q <= FLT_NONE;
                                state_q <= ST_DONE;
                            end
                        end
                        DK_XLAT: begin
                            pa_q    <= '0;
                            fault_q <= FLT_XLAT;
                            state_q <= ST_FAULT;
                        end
                        default: begin
                            pa_q    <= '0;
                            fault_q <= FLT_EXTABT;
                            state_q <= ST_FAULT;
                        end
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_valid = (state_q == ST_FETCH);
    assign done         = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign fault        = fault_q;
    assign out_pa       = pa_q;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk
    import xw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            cfg_bypass,
    input logic            cfg_disable,
    input logic            mem_rd_valid,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic [1:0]      fault,
    input logic [VA_W-1:0] out_pa
);
    logic            busy;
    logic            byp_pend;
    logic [VA_W-1:0] byp_va;
    logic            rd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            byp_pend <= 1'b0;
            byp_va   <= '0;
            rd_pend  <= 1'b0;
        end else begin
            if (!busy && req_valid) begin
                busy     <= 1'b1;
                byp_pend <= cfg_bypass | cfg_disable;
                byp_va   <= req_va;
            end else if (done) begin
                busy     <= 1'b0;
                byp_pend <= 1'b0;
            end
            if (mem_rd_valid) rd_pend <= 1'b1;
            else if (mem_rsp_valid) rd_pend <= 1'b0;
        end
    end

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst) mem_rd_valid |-> !rd_pend); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
    AST_DONE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> busy); // R11
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (rst) (done && fault != 2'd0) |-> out_pa == '0); // R11
    AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (rst) (done && byp_pend) |-> (fault == 2'd0 && out_pa == byp_va)); // R9
    AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (rst) byp_pend |-> !mem_rd_valid); // R9
endmodule

bind xlat_walker xw_walker_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .cfg_bypass    (cfg_bypass),
    .cfg_disable   (cfg_disable),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .out_pa        (out_pa)
);

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [63:0] cfg_tbl_base = '0;
    logic [1:0]  cfg_gran = '0;
    logic [1:0]  cfg_start_lvl = '0;
    logic [5:0]  cfg_tsz = 6'd16;
    logic        cfg_bypass = 1'b0;
    logic        cfg_disable = 1'b0;
    logic        mem_rd_valid;
    logic [47:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done;
    logic [1:0]  fault;
    logic [47:0] out_pa;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    bit finished = 0;

    logic [63:0] mem_img [logic [47:0]];
    bit          err_img [logic [47:0]];

    typedef struct {
        logic [1:0]  f;
        logic [47:0] pa;
        int          reads;
        int          rd0;
        string       req;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    xlat_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_rd(req_rd), .req_wr(req_wr), .cfg_tbl_base(cfg_tbl_base),
        .cfg_gran(cfg_gran), .cfg_start_lvl(cfg_start_lvl), .cfg_tsz(cfg_tsz),
        .cfg_bypass(cfg_bypass), .cfg_disable(cfg_disable),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .done(done), .fault(fault), .out_pa(out_pa)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // memory model: one response two negedges after each request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                logic [47:0] a;
                a = mem_rd_addr;
                rd_count++;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_img.exists(a) ? mem_img[a] : 64'h0;
                mem_rsp_err   = err_img.exists(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 64'(done), 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fault == e.f, e.req, {e.tag, " fault"}, 64'(fault), 64'(e.f));
                    check(out_pa == e.pa, e.req, {e.tag, " out_pa"}, 64'(out_pa), 64'(e.pa));
                    check((rd_count - e.rd0) == e.reads, e.req, {e.tag, " reads"},
                          64'(rd_count - e.rd0), 64'(e.reads));
                    @(negedge clk);
                    check(!done, "R11", {e.tag, " done width"}, 64'(done), 64'h0);
                end
            end
        end
    end

    task automatic issue(input logic [47:0] va, input bit wr, input logic [1:0] f,
                         input logic [47:0] pa, input int reads,
                         input string req, input string tag);
        exp_t e;
        e.f = f; e.pa = pa; e.reads = reads; e.rd0 = rd_count; e.req = req; e.tag = tag;
        exp_q.push_back(e);
        req_va    = va;
        req_wr    = wr;
        req_rd    = !wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // 4 KB tables rooted at 0x1000
        mem_img[48'h1000] = 64'h0000_0000_0000_2003;
        mem_img[48'h1008] = 64'h0000_0080_0000_0001;     // level-0 block: illegal
        mem_img[48'h2008] = 64'h0000_0000_0000_3003;
        mem_img[48'h2010] = 64'h4000_0000_0000_5003;     // read-only table
        mem_img[48'h2018] = 64'h0000_0040_0000_0001;     // 1 GB block
        mem_img[48'h3010] = 64'h0000_0000_0000_4003;
        mem_img[48'h3028] = 64'h0010_0001_2340_0401;     // 2 MB block, stray bits
        mem_img[48'h4018] = 64'h0000_0087_6543_3003;     // writable page
        mem_img[48'h4020] = 64'h0000_0011_2222_3083;     // read-only page
        mem_img[48'h4028] = 64'h0000_0000_0007_7001;     // reserved at level 3
        err_img[48'h4030] = 1'b1;
        mem_img[48'h5000] = 64'h0000_0000_0000_6003;
        mem_img[48'h6000] = 64'h0000_0000_0009_9003;
        // 16 KB tables rooted at 0x20000 (level 2)
        mem_img[48'h2_0018] = 64'h0000_0000_0002_4003;
        mem_img[48'h2_0020] = 64'h0000_0003_0000_0001;
        mem_img[48'h2_4010] = 64'h0000_0005_5555_C003;
        // 64 KB table rooted at 0x40000 (level 2)
        mem_img[48'h4_0008] = 64'h0000_0000_6000_0001;

        cfg_tbl_base = 64'hFFFF_0000_0000_1000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1", "reset done", 64'(done), 64'h0);
        check(mem_rd_valid == 1'b0, "R1", "reset mem_rd_valid", 64'(mem_rd_valid), 64'h0);
        check(fault == 2'd0, "R1", "reset fault", 64'(fault), 64'h0);
        check(out_pa == '0, "R1", "reset out_pa", 64'(out_pa), 64'h0);

        // 4 KB, start level 0
        issue(48'h4040_3ABC, 0, 2'd0, 48'h87_6543_3ABC, 4, "R2", "4k page rd");
        issue(48'h4040_3ABC, 1, 2'd0, 48'h87_6543_3ABC, 4, "R6", "4k page wr");
        issue(48'h4040_4ABC, 0, 2'd0, 48'h11_2222_3ABC, 4, "R7", "ro leaf rd");
        issue(48'h4040_4ABC, 1, 2'd3, 48'h0, 4, "R7", "ro leaf wr");
        issue(48'h8000_0123, 0, 2'd0, 48'h9_9123, 4, "R7", "ro table rd");
        issue(48'h8000_0123, 1, 2'd3, 48'h0, 4, "R7", "ro table wr");
        issue(48'h40A1_2345, 1, 2'd0, 48'h1_2341_2345, 3, "R5", "2M block");
        issue(48'hD234_5678, 0, 2'd0, 48'h40_1234_5678, 2, "R4", "1G block");
        issue(48'h1_0000_0000, 0, 2'd1, 48'h0, 2, "R3", "invalid entry");
        issue(48'h4040_5000, 0, 2'd1, 48'h0, 4, "R3", "reserved l3");
        issue(48'h4040_6000, 0, 2'd2, 48'h0, 4, "R8", "memory error");
        issue(48'h80_0000_0000, 0, 2'd2, 48'h0, 1, "R4", "level0 block");

        // bypass and disable
        cfg_bypass = 1'b1;
        issue(48'h1234_5678_9ABC, 1, 2'd0, 48'h1234_5678_9ABC, 0, "R9", "bypass");
        cfg_bypass = 1'b0; cfg_disable = 1'b1;
        issue(48'hFEDC_BA98_7654, 0, 2'd0, 48'hFEDC_BA98_7654, 0, "R9", "disable");
        cfg_disable = 1'b0;

        // input limit with tsz=25: limit 2^39-1
        cfg_tsz = 6'd25;
        issue(48'h7F_FFFF_FFFF, 0, 2'd1, 48'h0, 0, "R10", "at limit");
        issue(48'h7F_FFFF_FFFE, 0, 2'd1, 48'h0, 2, "R10", "below limit");
        cfg_tsz = 6'd16;

        // reserved granule code
        cfg_gran = 2'd3;
        issue(48'h4040_3ABC, 0, 2'd1, 48'h0, 0, "R2", "granule code 3");

        // 16 KB, start level 2
        cfg_gran = 2'd1; cfg_start_lvl = 2'd2; cfg_tbl_base = 64'h2_0000;
        issue(48'h600_BABC, 0, 2'd0, 48'h5_5555_FABC, 2, "R2", "16k page");
        issue(48'h801_2345, 1, 2'd0, 48'h3_0001_2345, 1, "R4", "16k block");

        // 64 KB, start level 2
        cfg_gran = 2'd2; cfg_tbl_base = 64'h4_0000;
        issue(48'h2ABC_DEF0, 0, 2'd0, 48'h6ABC_DEF0, 1, "R6", "64k block");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule